// File: doc/BRIEF.md
# Disk Wait-State Ready Generator

This block drives the processor READY line of a floppy interface card. While software reads the data register of the disk controller chip and no byte is yet available, READY is pulled low, so the processor stalls in the middle of its bus cycle. The stall ends as soon as the controller raises its data-request or interrupt-request line.

A retriggerable motor monoflop bounds each stall. A 0-to-1 transition on the motor-trigger control bit starts a drive-enable interval of `MOTOR_CYCLES` clock cycles. The interval stands for about 4.23 s on the real card, and a bench shortens it. When the interval runs out, READY returns high at once. An access to an empty drive therefore cannot hang the bus forever.

The host bus reads the odd (low) byte of a word first. For that reason one variant keys the stall to the odd data-register strobe, and the other keys it to the even strobe. The parameter `KEY_ODD_BYTE` selects between the two. Address decoding, the controller chip and the data path sit outside this block.

Top module: `disk_wait_ready`

## Requirements
- R1: While `rst` is high, each rising edge sets `ready` to 1 and `motor_en` to 0, and clears the stored arm bit and the stored trigger level.
- R2: `ready` is 0 after an edge only when all of these hold: at that edge the selected access strobe was 1, `drq` was 0 and `intrq` was 0; the arm bit stored at the previous edge was 1; and `motor_en` is 1 after the edge.
- R3: An edge that samples `motor_trig` at 1, where the previous edge sampled it at 0, sets `motor_en`. `motor_en` then stays 1 for exactly `MOTOR_CYCLES` clock cycles.
- R4: Holding `motor_trig` at 1 does not lengthen the interval. A new 0-to-1 transition while `motor_en` is 1 restarts the full interval from that edge.
- R5: `ready` returns to 1 at the same edge at which `motor_en` falls, whatever the state of `drq` and `intrq`.
- R6: If `drq` or `intrq` is 1 at an edge, `ready` is 1 after that edge.
- R7: When `wait_arm` is 0, the stored arm bit is 0 after the next edge, and `ready` is 1 from the edge after that, whatever the state of `drq` and `intrq`.
- R8: With `KEY_ODD_BYTE` = 1 only `acc_odd` can start a stall. With `KEY_ODD_BYTE` = 0 only `acc_even` can start a stall.
- R9: If the selected access strobe is 0 at an edge, `ready` is 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_even | input | 1 | Decoded access to the even byte of the data register |
| acc_odd | input | 1 | Decoded access to the odd byte of the data register |
| wait_arm | input | 1 | Arm bit for wait-state generation |
| motor_trig | input | 1 | Motor-trigger control bit; a rising level starts the monoflop |
| drq | input | 1 | Controller data-request line, active high |
| intrq | input | 1 | Controller interrupt-request line, active high |
| ready | output | 1 | Processor READY; 0 stalls the bus cycle |
| motor_en | output | 1 | Drive-enable (motor) output of the monoflop |

## Verification
Timing is counted from one clock edge. A change on the access strobes, `drq` or `intrq` reaches `ready` one edge later. The same holds for a trigger rise reaching `motor_en`. A change on `wait_arm` takes two edges, because the arm bit is stored first. `motor_en` falls `MOTOR_CYCLES` edges after the edge that started it, and `ready` rises at that same edge. The bench changes inputs on the falling clock edge and samples on a later falling edge. It counts exactly the rising edges each result needs, including the cycle just before and just after the monoflop expires. Two instances run side by side, one per byte-key variant, on the same stimulus.

// File: rtl/dwr_pkg.sv
package dwr_pkg;

  // Terms that must all be true for the bus to be held
  typedef struct packed {
    logic acc;
    logic arm;
    logic drq;
    logic intrq;
    logic motor;
  } stall_terms_t;

  function automatic logic stall_now(input stall_terms_t t);
    return t.acc & t.arm & ~t.drq & ~t.intrq & t.motor;
  endfunction

endpackage

// File: rtl/dwr_ctl_regs.sv
module dwr_ctl_regs (
  input  logic clk,
  input  logic rst,
  input  logic wait_arm,
  input  logic motor_trig,
  output logic arm_q,
  output logic trig_rise
);

  logic trig_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      arm_q  <= wait_arm;
      trig_q <= motor_trig;
    end
  end

  assign trig_rise = motor_trig & ~trig_q & ~rst;

endmodule

// File: rtl/dwr_motor_mono.sv
module dwr_motor_mono #(
  parameter int unsigned MOTOR_CYCLES = 211_500_000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic motor_en,
  output logic motor_nxt
);

  localparam int unsigned CW = (MOTOR_CYCLES < 2) ? 1 : $clog2(MOTOR_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(MOTOR_CYCLES - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          en_nxt;

  always_comb begin
    en_nxt  = motor_en;
    cnt_nxt = cnt;
    if (start) begin
      en_nxt  = 1'b1;
      cnt_nxt = RELOAD;
    end else if (motor_en) begin
      if (cnt != '0) cnt_nxt = cnt - 1'b1;
      else           en_nxt  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      motor_en <= 1'b0;
      cnt      <= '0;
    end else begin
      motor_en <= en_nxt;
      cnt      <= cnt_nxt;
    end
  end

  assign motor_nxt = en_nxt & ~rst;

endmodule

// File: rtl/dwr_ready_reg.sv
module dwr_ready_reg
  import dwr_pkg::*;
#(
  parameter bit KEY_ODD_BYTE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_even,
  input  logic acc_odd,
  input  logic arm_q,
  input  logic drq,
  input  logic intrq,
  input  logic motor_nxt,
  output logic ready
);

  stall_terms_t terms;
  logic         acc_sel;

  assign acc_sel = KEY_ODD_BYTE ? acc_odd : acc_even;

  always_comb begin
    terms.acc   = acc_sel;
    terms.arm   = arm_q;
    terms.drq   = drq;
    terms.intrq = intrq;
    terms.motor = motor_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) ready <= 1'b1;
    else     ready <= ~stall_now(terms);
  end

endmodule

// File: rtl/disk_wait_ready.sv
module disk_wait_ready #(
  parameter int unsigned MOTOR_CYCLES = 211_500_000,
  parameter bit          KEY_ODD_BYTE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic acc_even,
  input  logic acc_odd,
  input  logic wait_arm,
  input  logic motor_trig,
  input  logic drq,
  input  logic intrq,
  output logic ready,
  output logic motor_en
);

  logic arm_q;
  logic trig_rise;
  logic motor_nxt;

  dwr_ctl_regs u_ctl (
    .clk        (clk),
    .rst        (rst),
    .wait_arm   (wait_arm),
    .motor_trig (motor_trig),
    .arm_q      (arm_q),
    .trig_rise  (trig_rise)
  );

  dwr_motor_mono #(.MOTOR_CYCLES(MOTOR_CYCLES)) u_mono (
    .clk       (clk),
    .rst       (rst),
    .start     (trig_rise),
    .motor_en  (motor_en),
    .motor_nxt (motor_nxt)
  );

  dwr_ready_reg #(.KEY_ODD_BYTE(KEY_ODD_BYTE)) u_rdy (
    .clk       (clk),
    .rst       (rst),
    .acc_even  (acc_even),
    .acc_odd   (acc_odd),
    .arm_q     (arm_q),
    .drq       (drq),
    .intrq     (intrq),
    .motor_nxt (motor_nxt),
    .ready     (ready)
  );

endmodule

// File: rtl/dwr_checker.sv
module dwr_checker #(
  parameter bit KEY_ODD_BYTE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic acc_even,
  input logic acc_odd,
  input logic wait_arm,
  input logic motor_trig,
  input logic drq,
  input logic intrq,
  input logic ready,
  input logic motor_en
);

  logic sel;
  assign sel = KEY_ODD_BYTE ? acc_odd : acc_even;

  p_reset_r1: assert property (@(posedge clk) rst |=> (ready && !motor_en))
    else $error("p_reset_r1");

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(sel && !drq && !intrq) &&
     $past(wait_arm, 2) && motor_en) |-> !ready)
    else $error("p_stall_r2");

  p_motor_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(motor_en) |-> $past(motor_trig))
    else $error("p_motor_rise_r3");

  p_motor_off_ready_r5: assert property (@(posedge clk) disable iff (rst)
    !motor_en |-> ready)
    else $error("p_motor_off_ready_r5");

  p_drq_release_r6: assert property (@(posedge clk) disable iff (rst)
    $past(drq) |-> ready)
    else $error("p_drq_release_r6");

  p_intrq_release_r6: assert property (@(posedge clk) disable iff (rst)
    $past(intrq) |-> ready)
    else $error("p_intrq_release_r6");

  p_disarmed_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(wait_arm, 2) |-> ready)
    else $error("p_disarmed_r7");

  p_no_access_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(sel) |-> ready)
    else $error("p_no_access_r9");

endmodule

bind disk_wait_ready dwr_checker #(.KEY_ODD_BYTE(KEY_ODD_BYTE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_even   (acc_even),
  .acc_odd    (acc_odd),
  .wait_arm   (wait_arm),
  .motor_trig (motor_trig),
  .drq        (drq),
  .intrq      (intrq),
  .ready      (ready),
  .motor_en   (motor_en)
);

// File: tb/disk_wait_ready_tb.sv
module disk_wait_ready_tb;

  localparam int N = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_even = 1'b0, acc_odd = 1'b0, arm = 1'b0, trig = 1'b0;
  logic drq = 1'b0, intrq = 1'b0;
  logic ready, motor_en, ready_e, motor_e;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  disk_wait_ready #(.MOTOR_CYCLES(N), .KEY_ODD_BYTE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .acc_even(acc_even), .acc_odd(acc_odd),
    .wait_arm(arm), .motor_trig(trig), .drq(drq), .intrq(intrq),
    .ready(ready), .motor_en(motor_en)
  );

  disk_wait_ready #(.MOTOR_CYCLES(N), .KEY_ODD_BYTE(1'b0)) u_dut_even (
    .clk(clk), .rst(rst), .acc_even(acc_even), .acc_odd(acc_odd),
    .wait_arm(arm), .motor_trig(trig), .drq(drq), .intrq(intrq),
    .ready(ready_e), .motor_en(motor_e)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // trig rises then falls; motor_en high after the first tick (k=1)
  task automatic fire_motor();
    trig = 1'b1; tick(1); trig = 1'b0;
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 ready", ready, 1'b1);
    check("R1 motor_en", motor_en, 1'b0);
    check("R1 ready even", ready_e, 1'b1);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_stall_and_release();
    arm = 1'b1; acc_odd = 1'b1;
    fire_motor();                                       // k=1
    check("R3 motor on", motor_en, 1'b1);
    tick(1);                                            // k=2
    check("R2 stall", ready, 1'b0);
    check("R8 even variant ignores odd", ready_e, 1'b1);
    drq = 1'b1; tick(1);                                // k=3
    check("R6 drq releases", ready, 1'b1);
    drq = 1'b0; tick(1);                                // k=4
    check("R2 stall again", ready, 1'b0);
    intrq = 1'b1; tick(1);                              // k=5
    check("R6 intrq releases", ready, 1'b1);
    intrq = 1'b0; tick(1);                              // k=6
    check("R2 stall after intrq", ready, 1'b0);
    arm = 1'b0; tick(1);                                // k=7
    check("R7 arm takes two edges", ready, 1'b0);
    tick(1);                                            // k=8
    check("R7 disarmed", ready, 1'b1);
    acc_odd = 1'b0; acc_even = 1'b1; arm = 1'b1;
    tick(2);                                            // k=10
    check("R9 odd dut no access", ready, 1'b1);
    check("R8 even variant stalls", ready_e, 1'b0);
    tick(10);                                           // k=20
    check("R3 motor last cycle", motor_e, 1'b1);
    check("R2 even still stalled", ready_e, 1'b0);
    tick(1);                                            // k=21
    check("R3 motor expired", motor_e, 1'b0);
    check("R5 ready released at expiry", ready_e, 1'b1);
    acc_even = 1'b0; arm = 1'b0;
    tick(2);
  endtask

  task automatic t_hold();
    trig = 1'b1;
    tick(N);
    check("R4 held high, last cycle", motor_en, 1'b1);
    tick(1);
    check("R4 held high does not extend", motor_en, 1'b0);
    tick(5);
    check("R4 still off while held", motor_en, 1'b0);
    trig = 1'b0; tick(1);
    trig = 1'b1; tick(1);
    check("R4 new rise restarts", motor_en, 1'b1);
    trig = 1'b0;
    tick(N + 2);
    check("R3 off after interval", motor_en, 1'b0);
  endtask

  task automatic t_retrigger();
    fire_motor();               // k=1
    tick(9);                    // k=10
    fire_motor();               // reload, k'=1
    tick(N - 1);                // k'=N, original would have ended
    check("R4 retrigger extends", motor_en, 1'b1);
    tick(1);
    check("R4 retrigger full interval", motor_en, 1'b0);
  endtask

  task automatic t_motor_off();
    arm = 1'b1; acc_odd = 1'b1;
    tick(3);
    check("R5 no stall with motor off", ready, 1'b1);
    arm = 1'b0; acc_odd = 1'b0;
    tick(1);
  endtask

  initial begin
    t_reset();
    t_stall_and_release();
    t_hold();
    t_retrigger();
    t_motor_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule